// File: doc/BRIEF.md
# Fixed-Length RISC Instruction Decoder

This block is a purely combinational decoder for a 32-bit, fixed-length, load/store instruction word. It recognises which of three field layouts the word uses from its opcode: register, immediate or jump. It breaks the word into its fields and produces an immediate that is already widened to the datapath width. It also drives the control lines that a simple execution stage needs: register write, destination choice, ALU operand choice, memory read and write, byte access, branch, jump and link, and an ALU operation code.

The supported set is add, sub, and, or, slt, sll, srl, sra and jr in the register layout; addi, slti, lui, lw, lb, sw, sb, beq and bne in the immediate layout; and j and jal in the jump layout. Any other opcode, or any unknown function code under opcode 0, raises an illegal flag and silences every side effect. The block has no clock. It sits between an instruction register and the register file, ALU and memory port, all of which lie outside it.

Top module: `instr_decoder`

## Requirements
- R1: Fields are taken from fixed bit positions: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], shift amount [10:6], function [5:0], 16-bit immediate [15:0] and 26-bit target [25:0]. The word 0x00430820 yields rd=1, rs=2, rt=3, shift amount 0 and function 32.
- R2: The format output is 0 for opcode 0 (register), 1 for opcodes 4, 5, 8, 10, 15, 32, 35, 40 and 43 (immediate), 2 for opcodes 2 and 3 (jump), and 3 for any other opcode.
- R3: Under opcode 0, the function codes select these alu_op values: 32 add gives 0, 34 sub gives 1, 36 and gives 2, 37 or gives 3, 42 slt gives 4 (signed less-than), 0 sll gives 5, 2 srl gives 6 and 3 sra gives 7. Function 8 (jr) is a legal jump through rs. addi, loads, stores and jumps use alu_op 0, slti uses 4 and lui uses 8.
- R4: A writing register-format instruction writes to rd with alu_src_imm low.
- R5: A writing immediate-format instruction (addi, slti, lui, lw, lb) writes to rt with alu_src_imm high.
- R6: lw (35) and lb (32) assert mem_read, and sw (43) and sb (40) assert mem_write. mem_byte marks lb and sb. Stores and loads use alu_src_imm, and mem_read and mem_write are never high together.
- R7: jal (3) asserts jump, link and reg_write with destination 31. j (2) asserts jump only. jr asserts jump and jump_reg without a register write.
- R8: When reg_write is low, the destination output is 0. A write to register 0 is still signalled with reg_write high.
- R9: The immediate output is the sign-extended 16-bit field for every immediate-format opcode except lui. For lui it is the field placed in the upper half with a zero low half. For the register and jump formats it is 0.
- R10: beq (4) and bne (5) assert branch with alu_op 1, and branch_ne is high only for bne.
- R11: An unsupported opcode or function code raises illegal and holds reg_write, mem_read, mem_write, branch, jump, link and jump_reg low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word to decode |
| fmt | output | 2 | Layout class: 0 register, 1 immediate, 2 jump, 3 unknown |
| opcode | output | 6 | Opcode field |
| rs | output | 5 | First source register field |
| rt | output | 5 | Second source / immediate destination field |
| rd | output | 5 | Register-format destination field |
| shamt | output | 5 | Shift amount field |
| funct | output | 6 | Function field |
| jtarget | output | 26 | Jump target field |
| imm_ext | output | 32 | Widened immediate |
| reg_write | output | 1 | Register file write enable |
| dst_reg | output | 5 | Register to be written |
| alu_src_imm | output | 1 | ALU second operand comes from imm_ext |
| alu_op | output | 4 | ALU operation code |
| mem_read | output | 1 | Memory load |
| mem_write | output | 1 | Memory store |
| mem_byte | output | 1 | Memory access is one byte wide |
| branch | output | 1 | Conditional branch |
| branch_ne | output | 1 | Branch taken on inequality |
| jump | output | 1 | Unconditional transfer |
| jump_reg | output | 1 | Transfer target comes from rs |
| link | output | 1 | Return address is written |
| illegal | output | 1 | Unsupported encoding |

## Verification
The bench builds the decoder with its default parameters: a 32-bit data path, 5-bit register indices and link register 31. These values make the 16-to-32 sign extension and the lui upper-half placement visible at full width. They also let a jal word be compared against destination 31 and the standard field boundaries be read from real encodings. The vector walk covers every supported operation class plus both kinds of illegal encoding. Directed checks then probe the memory, branch and jump lines and an rd=0 write.

// File: rtl/instr_decoder_pkg.sv
package instr_decoder_pkg;

  typedef enum logic [1:0] {
    FMT_REG  = 2'd0,
    FMT_IMM  = 2'd1,
    FMT_JMP  = 2'd2,
    FMT_NONE = 2'd3
  } fmt_e;

  typedef enum logic [3:0] {
    ALU_ADD = 4'd0,
    ALU_SUB = 4'd1,
    ALU_AND = 4'd2,
    ALU_OR  = 4'd3,
    ALU_SLT = 4'd4,
    ALU_SLL = 4'd5,
    ALU_SRL = 4'd6,
    ALU_SRA = 4'd7,
    ALU_LUI = 4'd8
  } alu_op_e;

  typedef enum logic [1:0] {
    IMM_ZERO  = 2'd0,
    IMM_SEXT  = 2'd1,
    IMM_UPPER = 2'd2
  } imm_kind_e;

  localparam logic [5:0] OP_REG  = 6'd0;
  localparam logic [5:0] OP_J    = 6'd2;
  localparam logic [5:0] OP_JAL  = 6'd3;
  localparam logic [5:0] OP_BEQ  = 6'd4;
  localparam logic [5:0] OP_BNE  = 6'd5;
  localparam logic [5:0] OP_ADDI = 6'd8;
  localparam logic [5:0] OP_SLTI = 6'd10;
  localparam logic [5:0] OP_LUI  = 6'd15;
  localparam logic [5:0] OP_LB   = 6'd32;
  localparam logic [5:0] OP_LW   = 6'd35;
  localparam logic [5:0] OP_SB   = 6'd40;
  localparam logic [5:0] OP_SW   = 6'd43;

  localparam logic [5:0] FN_SLL = 6'd0;
  localparam logic [5:0] FN_SRL = 6'd2;
  localparam logic [5:0] FN_SRA = 6'd3;
  localparam logic [5:0] FN_JR  = 6'd8;
  localparam logic [5:0] FN_ADD = 6'd32;
  localparam logic [5:0] FN_SUB = 6'd34;
  localparam logic [5:0] FN_AND = 6'd36;
  localparam logic [5:0] FN_OR  = 6'd37;
  localparam logic [5:0] FN_SLT = 6'd42;

endpackage

// File: rtl/instr_decoder_fields.sv
module instr_decoder_fields #(
  parameter int IW    = 32,
  parameter int OP_W  = 6,
  parameter int RA_W  = 5,
  parameter int FN_W  = 6,
  parameter int IMM_W = 16,
  parameter int TGT_W = 26
) (
  input  logic [IW-1:0]    word,
  output logic [OP_W-1:0]  f_op,
  output logic [RA_W-1:0]  f_rs,
  output logic [RA_W-1:0]  f_rt,
  output logic [RA_W-1:0]  f_rd,
  output logic [RA_W-1:0]  f_sh,
  output logic [FN_W-1:0]  f_fn,
  output logic [IMM_W-1:0] f_imm,
  output logic [TGT_W-1:0] f_tgt
);
  localparam int RS_LO = IW - OP_W - RA_W;
  localparam int RT_LO = RS_LO - RA_W;
  localparam int RD_LO = RT_LO - RA_W;
  localparam int SH_LO = RD_LO - RA_W;

  always_comb begin
    f_op  = word[IW-1 -: OP_W];
    f_rs  = word[RS_LO +: RA_W];
    f_rt  = word[RT_LO +: RA_W];
    f_rd  = word[RD_LO +: RA_W];
    f_sh  = word[SH_LO +: RA_W];
    f_fn  = word[FN_W-1:0];
    f_imm = word[IMM_W-1:0];
    f_tgt = word[TGT_W-1:0];
  end
endmodule

// File: rtl/instr_decoder_func.sv
module instr_decoder_func
  import instr_decoder_pkg::*;
(
  input  logic [5:0] fn,
  output alu_op_e    fn_alu,
  output logic       fn_valid,
  output logic       fn_is_jr
);
  always_comb begin
    fn_alu   = ALU_ADD;
    fn_valid = 1'b1;
    fn_is_jr = 1'b0;
    case (fn)
      FN_ADD: fn_alu = ALU_ADD;
      FN_SUB: fn_alu = ALU_SUB;
      FN_AND: fn_alu = ALU_AND;
      FN_OR:  fn_alu = ALU_OR;
      FN_SLT: fn_alu = ALU_SLT;
      FN_SLL: fn_alu = ALU_SLL;
      FN_SRL: fn_alu = ALU_SRL;
      FN_SRA: fn_alu = ALU_SRA;
      FN_JR:  fn_is_jr = 1'b1;
      default: fn_valid = 1'b0;
    endcase
  end
endmodule

// File: rtl/instr_decoder_imm.sv
module instr_decoder_imm
  import instr_decoder_pkg::*;
#(
  parameter int DW    = 32,
  parameter int IMM_W = 16
) (
  input  logic [IMM_W-1:0] imm,
  input  imm_kind_e        kind,
  output logic [DW-1:0]    imm_out
);
  localparam int EXT_W = DW - IMM_W;

  always_comb begin
    case (kind)
      IMM_SEXT:  imm_out = {{EXT_W{imm[IMM_W-1]}}, imm};
      IMM_UPPER: imm_out = {imm, {EXT_W{1'b0}}};
      default:   imm_out = '0;
    endcase
  end
endmodule

// File: rtl/instr_decoder_ctrl.sv
module instr_decoder_ctrl
  import instr_decoder_pkg::*;
#(
  parameter int RA_W = 5,
  parameter int LINK_REG = 31
) (
  input  logic [5:0]      op,
  input  logic [RA_W-1:0] rt_f,
  input  logic [RA_W-1:0] rd_f,
  input  alu_op_e         fn_alu,
  input  logic            fn_valid,
  input  logic            fn_is_jr,
  output fmt_e            fmt_o,
  output imm_kind_e       imm_kind,
  output logic            bad,
  output logic            wr_en,
  output logic [RA_W-1:0] wr_dst,
  output logic            src_imm,
  output alu_op_e         aop,
  output logic            ld,
  output logic            st,
  output logic            byte_acc,
  output logic            br,
  output logic            br_ne,
  output logic            jmp,
  output logic            jmp_reg,
  output logic            lnk
);
  localparam logic [RA_W-1:0] LINK_IDX = RA_W'(LINK_REG);

  logic           want_wr;
  logic [RA_W-1:0] want_dst;

  always_comb begin
    fmt_o    = FMT_NONE;
    imm_kind = IMM_ZERO;
    bad      = 1'b0;
    want_wr  = 1'b0;
    want_dst = rt_f;
    src_imm  = 1'b0;
    aop      = ALU_ADD;
    ld       = 1'b0;
    st       = 1'b0;
    byte_acc = 1'b0;
    br       = 1'b0;
    br_ne    = 1'b0;
    jmp      = 1'b0;
    jmp_reg  = 1'b0;
    lnk      = 1'b0;
    case (op)
      OP_REG: begin
        fmt_o = FMT_REG;
        if (!fn_valid) begin
          bad = 1'b1;
        end else if (fn_is_jr) begin
          jmp     = 1'b1;
          jmp_reg = 1'b1;
        end else begin
          want_wr  = 1'b1;
          want_dst = rd_f;
          aop      = fn_alu;
        end
      end
      OP_J: begin
        fmt_o = FMT_JMP;
        jmp   = 1'b1;
      end
      OP_JAL: begin
        fmt_o    = FMT_JMP;
        jmp      = 1'b1;
        lnk      = 1'b1;
        want_wr  = 1'b1;
        want_dst = LINK_IDX;
      end
      OP_BEQ, OP_BNE: begin
        fmt_o    = FMT_IMM;
        imm_kind = IMM_SEXT;
        br       = 1'b1;
        br_ne    = (op == OP_BNE);
        aop      = ALU_SUB;
      end
      OP_ADDI, OP_SLTI: begin
        fmt_o    = FMT_IMM;
        imm_kind = IMM_SEXT;
        want_wr  = 1'b1;
        src_imm  = 1'b1;
        aop      = (op == OP_SLTI) ? ALU_SLT : ALU_ADD;
      end
      OP_LUI: begin
        fmt_o    = FMT_IMM;
        imm_kind = IMM_UPPER;
        want_wr  = 1'b1;
        src_imm  = 1'b1;
        aop      = ALU_LUI;
      end
      OP_LB, OP_LW: begin
        fmt_o    = FMT_IMM;
        imm_kind = IMM_SEXT;
        want_wr  = 1'b1;
        src_imm  = 1'b1;
        ld       = 1'b1;
        byte_acc = (op == OP_LB);
      end
      OP_SB, OP_SW: begin
        fmt_o    = FMT_IMM;
        imm_kind = IMM_SEXT;
        src_imm  = 1'b1;
        st       = 1'b1;
        byte_acc = (op == OP_SB);
      end
      default: bad = 1'b1;
    endcase
    wr_en  = want_wr && !bad;
    wr_dst = wr_en ? want_dst : '0;
  end
endmodule

// File: rtl/instr_decoder.sv
module instr_decoder
  import instr_decoder_pkg::*;
#(
  parameter int DW       = 32,
  parameter int RA_W     = 5,
  parameter int LINK_REG = 31
) (
  input  logic [31:0]     instr,
  output logic [1:0]      fmt,
  output logic [5:0]      opcode,
  output logic [RA_W-1:0] rs,
  output logic [RA_W-1:0] rt,
  output logic [RA_W-1:0] rd,
  output logic [RA_W-1:0] shamt,
  output logic [5:0]      funct,
  output logic [25:0]     jtarget,
  output logic [DW-1:0]   imm_ext,
  output logic            reg_write,
  output logic [RA_W-1:0] dst_reg,
  output logic            alu_src_imm,
  output logic [3:0]      alu_op,
  output logic            mem_read,
  output logic            mem_write,
  output logic            mem_byte,
  output logic            branch,
  output logic            branch_ne,
  output logic            jump,
  output logic            jump_reg,
  output logic            link,
  output logic            illegal
);
  localparam int IMM_W = 16;

  logic [IMM_W-1:0] imm_raw;
  alu_op_e          fn_alu;
  logic             fn_valid;
  logic             fn_is_jr;
  fmt_e             fmt_e_w;
  imm_kind_e        imm_kind;
  alu_op_e          aop_w;

  instr_decoder_fields #(
    .IW(32), .OP_W(6), .RA_W(RA_W), .FN_W(6), .IMM_W(IMM_W), .TGT_W(26)
  ) u_fields (
    .word (instr),
    .f_op (opcode),
    .f_rs (rs),
    .f_rt (rt),
    .f_rd (rd),
    .f_sh (shamt),
    .f_fn (funct),
    .f_imm(imm_raw),
    .f_tgt(jtarget)
  );

  instr_decoder_func u_func (
    .fn      (funct),
    .fn_alu  (fn_alu),
    .fn_valid(fn_valid),
    .fn_is_jr(fn_is_jr)
  );

  instr_decoder_ctrl #(.RA_W(RA_W), .LINK_REG(LINK_REG)) u_ctrl (
    .op      (opcode),
    .rt_f    (rt),
    .rd_f    (rd),
    .fn_alu  (fn_alu),
    .fn_valid(fn_valid),
    .fn_is_jr(fn_is_jr),
    .fmt_o   (fmt_e_w),
    .imm_kind(imm_kind),
    .bad     (illegal),
    .wr_en   (reg_write),
    .wr_dst  (dst_reg),
    .src_imm (alu_src_imm),
    .aop     (aop_w),
    .ld      (mem_read),
    .st      (mem_write),
    .byte_acc(mem_byte),
    .br      (branch),
    .br_ne   (branch_ne),
    .jmp     (jump),
    .jmp_reg (jump_reg),
    .lnk     (link)
  );

  instr_decoder_imm #(.DW(DW), .IMM_W(IMM_W)) u_imm (
    .imm    (imm_raw),
    .kind   (imm_kind),
    .imm_out(imm_ext)
  );

  assign fmt    = fmt_e_w;
  assign alu_op = aop_w;
endmodule

// File: rtl/instr_decoder_chk.sv
module instr_decoder_chk #(
  parameter int DW       = 32,
  parameter int RA_W     = 5,
  parameter int LINK_REG = 31
) (
  input logic [31:0]     instr,
  input logic [1:0]      fmt,
  input logic [RA_W-1:0] rt,
  input logic [RA_W-1:0] rd,
  input logic [DW-1:0]   imm_ext,
  input logic            reg_write,
  input logic [RA_W-1:0] dst_reg,
  input logic [3:0]      alu_op,
  input logic            mem_read,
  input logic            mem_write,
  input logic            branch,
  input logic            jump,
  input logic            link,
  input logic            illegal
);
  always_comb begin
    if (!$isunknown(instr)) begin
      assert_illegal_quiet_R11: assert (!illegal ||
        (!reg_write && !mem_read && !mem_write && !branch && !jump && !link))
        else $error("illegal encoding with side effect");
      assert_link_dest_R7: assert (!link || (reg_write && dst_reg == RA_W'(LINK_REG)))
        else $error("link without write to link register");
      assert_mem_exclusive_R6: assert (!(mem_read && mem_write))
        else $error("load and store together");
      assert_imm_dest_R5: assert (!(fmt == 2'd1 && reg_write) || dst_reg == rt)
        else $error("immediate format writes other than rt");
      assert_reg_dest_R4: assert (!(fmt == 2'd0 && reg_write) || dst_reg == rd)
        else $error("register format writes other than rd");
      assert_idle_dest_R8: assert (reg_write || dst_reg == '0)
        else $error("destination nonzero without write");
      assert_upper_low_zero_R9: assert (illegal || alu_op != 4'd8 || imm_ext[DW/2-1:0] == '0)
        else $error("upper immediate low half nonzero");
    end
  end
endmodule

bind instr_decoder instr_decoder_chk #(.DW(DW), .RA_W(RA_W), .LINK_REG(LINK_REG)) u_chk (.*);

// File: tb/instr_decoder_bench.sv
module instr_decoder_bench;
  typedef struct packed {
    logic [31:0] word;
    logic        ill;
    logic        wr;
    logic [4:0]  dst;
    logic [3:0]  aop;
    logic [1:0]  fm;
    logic [31:0] imm;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VEC [NV] = '{
    '{32'h00430820, 1'b0, 1'b1, 5'd1,  4'd0, 2'd0, 32'h00000000}, // R3 add
    '{32'h00A62022, 1'b0, 1'b1, 5'd4,  4'd1, 2'd0, 32'h00000000}, // R3 sub
    '{32'h0109382A, 1'b0, 1'b1, 5'd7,  4'd4, 2'd0, 32'h00000000}, // R3 slt
    '{32'h00031100, 1'b0, 1'b1, 5'd2,  4'd5, 2'd0, 32'h00000000}, // R3 sll
    '{32'h2149FFFF, 1'b0, 1'b1, 5'd9,  4'd0, 2'd1, 32'hFFFFFFFF}, // R5 addi
    '{32'h3C031234, 1'b0, 1'b1, 5'd3,  4'd8, 2'd1, 32'h12340000}, // R9 lui
    '{32'h8FA50008, 1'b0, 1'b1, 5'd5,  4'd0, 2'd1, 32'h00000008}, // R6 lw
    '{32'hAFA5FFFC, 1'b0, 1'b0, 5'd0,  4'd0, 2'd1, 32'hFFFFFFFC}, // R6 sw
    '{32'h1022FFFE, 1'b0, 1'b0, 5'd0,  4'd1, 2'd1, 32'hFFFFFFFE}, // R10 beq
    '{32'h0C000100, 1'b0, 1'b1, 5'd31, 4'd0, 2'd2, 32'h00000000}, // R7 jal
    '{32'h03E00008, 1'b0, 1'b0, 5'd0,  4'd0, 2'd0, 32'h00000000}, // R7 jr
    '{32'hFC000000, 1'b1, 1'b0, 5'd0,  4'd0, 2'd3, 32'h00000000}, // R11 opcode
    '{32'h00430821, 1'b1, 1'b0, 5'd0,  4'd0, 2'd0, 32'h00000000}, // R11 funct
    '{32'h28620005, 1'b0, 1'b1, 5'd2,  4'd4, 2'd1, 32'h00000005}, // R3 slti
    '{32'h80018000, 1'b0, 1'b1, 5'd1,  4'd0, 2'd1, 32'hFFFF8000}, // R9 lb
    '{32'h00430020, 1'b0, 1'b1, 5'd0,  4'd0, 2'd0, 32'h00000000}  // R8 rd zero
  };

  logic clk;
  logic rst_n;
  logic [31:0] instr;
  logic [1:0]  fmt;
  logic [5:0]  opcode, funct;
  logic [4:0]  rs, rt, rd, shamt, dst_reg;
  logic [25:0] jtarget;
  logic [31:0] imm_ext;
  logic [3:0]  alu_op;
  logic reg_write, alu_src_imm, mem_read, mem_write, mem_byte;
  logic branch, branch_ne, jump, jump_reg, link, illegal;
  int n_run;
  int n_fail;
  bit done;

  instr_decoder u_instr_decoder (
    .instr(instr), .fmt(fmt), .opcode(opcode), .rs(rs), .rt(rt), .rd(rd),
    .shamt(shamt), .funct(funct), .jtarget(jtarget), .imm_ext(imm_ext),
    .reg_write(reg_write), .dst_reg(dst_reg), .alu_src_imm(alu_src_imm),
    .alu_op(alu_op), .mem_read(mem_read), .mem_write(mem_write),
    .mem_byte(mem_byte), .branch(branch), .branch_ne(branch_ne),
    .jump(jump), .jump_reg(jump_reg), .link(link), .illegal(illegal)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] w);
    @(negedge clk);
    instr = w;
    #2;
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    n_run = 0;
    n_fail = 0;
    done = 1'b0;
    rst_n = 1'b0;
    instr = 32'h0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    #2;
    // reset state: the all-zero word is sll r0,r0,0 and writes r0 (R8)
    check("R8 reset word write", {31'd0, reg_write}, 32'd1);
    check("R8 reset word dest", {27'd0, dst_reg}, 32'd0);
    check("R11 reset word legal", {31'd0, illegal}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].word);
      check($sformatf("R11 vec%0d illegal", i), {31'd0, illegal}, {31'd0, VEC[i].ill});
      check($sformatf("R8 vec%0d write", i), {31'd0, reg_write}, {31'd0, VEC[i].wr});
      check($sformatf("R4 vec%0d dest", i), {27'd0, dst_reg}, {27'd0, VEC[i].dst});
      check($sformatf("R3 vec%0d aluop", i), {28'd0, alu_op}, {28'd0, VEC[i].aop});
      check($sformatf("R2 vec%0d fmt", i), {30'd0, fmt}, {30'd0, VEC[i].fm});
      check($sformatf("R9 vec%0d imm", i), imm_ext, VEC[i].imm);
    end

    // R1 field split on the add word
    apply(32'h00430820);
    check("R1 opcode", {26'd0, opcode}, 32'd0);
    check("R1 rs", {27'd0, rs}, 32'd2);
    check("R1 rt", {27'd0, rt}, 32'd3);
    check("R1 rd", {27'd0, rd}, 32'd1);
    check("R1 shamt", {27'd0, shamt}, 32'd0);
    check("R1 funct", {26'd0, funct}, 32'd32);
    check("R4 src reg", {31'd0, alu_src_imm}, 32'd0);

    // R6 memory controls
    apply(32'h8FA50008);
    check("R6 lw read/write/byte/src", {28'd0, mem_read, mem_write, mem_byte, alu_src_imm}, 32'b1001);
    apply(32'h80018000);
    check("R6 lb read/write/byte", {29'd0, mem_read, mem_write, mem_byte}, 32'b101);
    apply(32'hAFA5FFFC);
    check("R6 sw read/write/byte/src", {28'd0, mem_read, mem_write, mem_byte, alu_src_imm}, 32'b0101);
    apply(32'hA3A5FFFC);
    check("R6 sb read/write/byte", {29'd0, mem_read, mem_write, mem_byte}, 32'b011);
    apply(32'h2149FFFF);
    check("R5 addi src imm", {31'd0, alu_src_imm}, 32'd1);

    // R10 branches
    apply(32'h1022FFFE);
    check("R10 beq branch/ne", {30'd0, branch, branch_ne}, 32'b10);
    apply(32'h1422FFFE);
    check("R10 bne branch/ne", {30'd0, branch, branch_ne}, 32'b11);
    check("R10 bne aluop", {28'd0, alu_op}, 32'd1);

    // R7 jumps
    apply(32'h0C000100);
    check("R7 jal jump/reg/link", {29'd0, jump, jump_reg, link}, 32'b101);
    apply(32'h08000ABC);
    check("R7 j jump/reg/link/write", {28'd0, jump, jump_reg, link, reg_write}, 32'b1000);
    check("R1 jtarget", {6'd0, jtarget}, 32'h00000ABC);
    check("R2 j fmt", {30'd0, fmt}, 32'd2);
    apply(32'h03E00008);
    check("R7 jr jump/reg/link", {29'd0, jump, jump_reg, link}, 32'b110);

    // R11 illegal silences memory and branch lines
    apply(32'hFC000000);
    check("R11 illegal quiet", {26'd0, mem_read, mem_write, branch, jump, link, jump_reg}, 32'd0);

    done = 1'b1;
    finish_run();
  end
endmodule